// File: doc/BRIEF.md
# Rail Fault Supervisor

This block watches one output rail of a multiphase buck controller from the digital side. Each clock it takes a sampled output-voltage code, the VID target code, a summed phase-current code and a current-limit code, along with two dynamic-VID flags and a strobe that marks a PWM on-pulse. From these it decides over-voltage, under-voltage and summed over-current faults. Each fault has its own persistence filter and its own masking rules. The first fault to qualify is latched until reset. Reset stands for a supply or enable toggle.

A latched fault pulls the ready output low and sends a drive command to the PWM stage. Over-voltage holds every phase low, then drops to a no-on-pulse mode once the output has discharged. A fixed time later it walks the DAC target down to zero. Under-voltage and over-current put every phase in tri-state. Voltage codes use a 5 mV step, so 9 bits are needed to reach the raised start-up threshold. All windows are counted in clocks of a parameterised clock rate. The defaults below assume 100 MHz.

Top module: `vr_fault_supervisor`

## Requirements
- R1: After reset, `vr_ready` is 1, `pwm_cmd` is 0 (run), `fault_code` is 0 (none) and `dac_target` equals `vid_code`.
- R2: Outside the start-up window, the over-voltage level is the larger of VID+70 codes (350 mV) and 270 codes (1.35 V). Only an output strictly above the level counts.
- R3: The start-up window opens when `vid_code` leaves 0. It closes on the first `pwm_pulse` sampled while `dvid_active` is low. While it is open, the over-voltage level is 490 codes (2.45 V).
- R4: An over-voltage condition seen on 50 consecutive clocks (0.5 µs) latches the fault on the 50th edge. From then on `vr_ready` is 0, `pwm_cmd` is 1 (all low) and `fault_code` is 1.
- R5: After an over-voltage trip, `pwm_cmd` stays 1 until the output falls strictly below 420 codes (2.1 V) or below the VID captured at the trip. The 420-code level applies if the trip happened inside the start-up window. From the following edge on, `pwm_cmd` is 3 (no on-pulses).
- R6: Once over-voltage has latched, `dac_target` holds the VID captured at the trip and ignores `vid_code`. It drops by one code at 6000 + RAMP_DIV edges after the trip (60 µs plus one step), then by one more code every RAMP_DIV edges, and stops at 0.
- R7: When `vout_code` + 130 (650 mV) < `vid_code` holds for 300 consecutive clocks (3 µs), the fault latches. `vr_ready` goes to 0, `pwm_cmd` to 2 (tri-state) and `fault_code` to 2.
- R8: When `isum_code` > `ilim_code` holds for 4000 consecutive unmasked clocks (40 µs), the fault latches. `vr_ready` goes to 0, `pwm_cmd` to 2 and `fault_code` to 3. Equality does not count.
- R9: During the first DVID-up transition after reset, and for 8000 clocks after it ends, over-current qualifies after 50 clocks instead of 4000.
- R10: Over-current is masked during every later DVID transition and for 8000 clocks after each one ends.
- R11: While `vid_code` is 0, neither over-voltage nor over-current can qualify.
- R12: If faults qualify on the same edge, over-voltage wins over under-voltage, which wins over over-current. Once latched, `fault_code` and `pwm_cmd` class do not change until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (supply/enable toggle) |
| vout_code | input | VW | Sampled output voltage, 5 mV per code |
| vid_code | input | VW | Present VID target, 5 mV per code |
| isum_code | input | IW | Summed phase current sample |
| ilim_code | input | IW | Summed over-current threshold |
| dvid_active | input | 1 | VID transition in progress |
| dvid_up | input | 1 | Direction of the transition, 1 = rising |
| pwm_pulse | input | 1 | One-clock strobe per PWM on-pulse |
| vr_ready | output | 1 | 1 while no fault is latched |
| pwm_cmd | output | 2 | 0 run, 1 all low, 2 tri-state, 3 no on-pulses |
| fault_code | output | 2 | 0 none, 1 over-voltage, 2 under-voltage, 3 over-current |
| dac_target | output | VW | VID to use for the DAC (ramped after over-voltage) |

## Verification
Each result has a fixed latency. A fault condition first sampled at edge k latches at edge k+N−1, where N is 50, 300 or 4000 clocks. The ready and drive outputs change after that same edge. The release to no-on-pulse mode takes effect one edge after the low output is sampled. The first ramp step lands exactly 6000+RAMP_DIV edges after the trip edge. The driver records the edge count whenever it applies a stimulus. It pushes each expected value tagged with the absolute edge at which it is due, and usually also the edge just before, where the old value must still hold. The monitor compares on the falling clock edge, only against entries due on that edge, so a result that arrives one clock early or late is reported.

// File: rtl/vr_sup_pkg.sv
package vr_sup_pkg;

   typedef enum logic [1:0] {
      FLT_NONE = 2'd0,
      FLT_OV   = 2'd1,
      FLT_UV   = 2'd2,
      FLT_OC   = 2'd3
   } flt_e;

   typedef enum logic [1:0] {
      DRV_RUN  = 2'd0,
      DRV_LOW  = 2'd1,
      DRV_TRI  = 2'd2,
      DRV_NOON = 2'd3
   } drv_e;

   localparam int FILTER_COUNT = 3;
   localparam int IDX_OV = 0;
   localparam int IDX_UV = 1;
   localparam int IDX_OC = 2;

   function automatic int mv_to_code(input int mv, input int lsb_mv);
      return mv / lsb_mv;
   endfunction

   function automatic int us_to_clk(input int tenth_us, input int clk_mhz);
      return (tenth_us * clk_mhz) / 10;
   endfunction

endpackage

// File: rtl/vr_persist_filter.sv
module vr_persist_filter #(
   parameter int CW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cond,
   input  logic [CW-1:0] limit,
   output logic          hit
);

   logic [CW-1:0] cnt;
   logic          at_lim;

   assign at_lim = (cnt >= limit - CW'(1));
   assign hit    = cond & at_lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (!cond)   cnt <= '0;
      else if (!at_lim) cnt <= cnt + CW'(1);
   end

   // a qualified hit needs the condition on the previous edge as well
   assert_persist_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> $past(cond));

endmodule

// File: rtl/vr_ov_window.sv
module vr_ov_window #(
   parameter int VW      = 9,
   parameter int OFS_C   = 70,
   parameter int FLOOR_C = 270,
   parameter int BOOT_C  = 490,
   parameter int BREL_C  = 420
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [VW-1:0] vid_code,
   input  logic [VW-1:0] vout_code,
   input  logic          dvid_active,
   input  logic          pwm_pulse,
   input  logic          take,
   input  logic          latched,
   output logic          ov_cond,
   output logic          released
);

   localparam logic [VW:0] FLOOR_W = (VW+1)'(FLOOR_C);
   localparam logic [VW:0] BOOT_W  = (VW+1)'(BOOT_C);
   localparam logic [VW:0] BREL_W  = (VW+1)'(BREL_C);

   logic          vid_zero, vid_zero_q;
   logic          boot_win, boot_eff, boot_cap;
   logic [VW-1:0] vid_cap;
   logic [VW:0]   thr_n, thr, rel_lvl;

   assign vid_zero = (vid_code == '0);
   assign boot_eff = boot_win | (vid_zero_q & ~vid_zero);

   always_comb begin
      thr_n = {1'b0, vid_code} + (VW+1)'(OFS_C);
      if (thr_n < FLOOR_W) thr_n = FLOOR_W;
      thr = boot_eff ? BOOT_W : thr_n;
   end

   assign ov_cond = ~vid_zero & ({1'b0, vout_code} > thr);
   assign rel_lvl = boot_cap ? BREL_W : {1'b0, vid_cap};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vid_zero_q <= 1'b0;
         boot_win   <= 1'b0;
      end else begin
         vid_zero_q <= vid_zero;
         if (vid_zero)                       boot_win <= 1'b0;
         else if (vid_zero_q)                boot_win <= 1'b1;
         else if (pwm_pulse && !dvid_active) boot_win <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         boot_cap <= 1'b0;
         vid_cap  <= '0;
         released <= 1'b0;
      end else begin
         if (take) begin
            boot_cap <= boot_eff;
            vid_cap  <= vid_code;
         end
         if (latched && !released && ({1'b0, vout_code} < rel_lvl))
            released <= 1'b1;
      end
   end

   // release is only possible once the trip is latched
   assert_release_after_trip_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(released) |-> $past(latched));

endmodule

// File: rtl/vr_oc_window.sv
module vr_oc_window #(
   parameter int POST = 8000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dvid_active,
   input  logic dvid_up,
   input  logic vid_zero,
   output logic oc_mask,
   output logic oc_short
);

   localparam int PW = $clog2(POST + 1);

   logic          dvid_q, first_seen, in_first;
   logic          rise, fall, first_now, win;
   logic [PW-1:0] post_cnt;

   assign rise      = dvid_active & ~dvid_q;
   assign fall      = ~dvid_active & dvid_q;
   assign first_now = (in_first & ~rise) | (rise & dvid_up & ~first_seen);
   assign win       = dvid_active | fall | (post_cnt != '0);
   assign oc_mask   = vid_zero | (win & ~first_now);
   assign oc_short  = win & first_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dvid_q     <= 1'b0;
         first_seen <= 1'b0;
         in_first   <= 1'b0;
         post_cnt   <= '0;
      end else begin
         dvid_q <= dvid_active;
         if (rise && dvid_up) first_seen <= 1'b1;
         if (rise)
            in_first <= dvid_up & ~first_seen;
         else if (!dvid_active && post_cnt == PW'(1))
            in_first <= 1'b0;
         if (dvid_active)          post_cnt <= '0;
         else if (fall)            post_cnt <= PW'(POST);
         else if (post_cnt != '0)  post_cnt <= post_cnt - PW'(1);
      end
   end

   // a later transition never gets the short filter
   assert_first_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && first_seen) |-> !oc_short);

endmodule

// File: rtl/vr_ov_ramp.sv
module vr_ov_ramp #(
   parameter int VW    = 9,
   parameter int DELAY = 6000,
   parameter int DIV   = 100
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic          hold,
   input  logic [VW-1:0] vid_code,
   output logic [VW-1:0] dac_target
);

   localparam int TW = $clog2(DELAY + 1);

   logic [TW-1:0] tmr;
   logic [VW-1:0] tgt_q;
   logic          ramp_on;
   logic          step_now;

   assign ramp_on    = (tmr == TW'(DELAY));
   assign dac_target = hold ? tgt_q : vid_code;

   generate
      if (DIV > 1) begin : g_div
         localparam int SW = $clog2(DIV);
         logic [SW-1:0] step;
         assign step_now = ramp_on & (step == SW'(DIV - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  step <= '0;
            else if (take)               step <= '0;
            else if (hold && ramp_on)    step <= step_now ? '0 : step + SW'(1);
         end
      end else begin : g_every
         assign step_now = ramp_on;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr   <= '0;
         tgt_q <= '0;
      end else if (take) begin
         tmr   <= '0;
         tgt_q <= vid_code;
      end else if (hold) begin
         if (!ramp_on) tmr <= tmr + TW'(1);
         if (step_now && tgt_q != '0) tgt_q <= tgt_q - VW'(1);
      end
   end

   assert_ramp_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !take) |=> (tgt_q <= $past(tgt_q)));

endmodule

// File: rtl/vr_fault_supervisor.sv
module vr_fault_supervisor
   import vr_sup_pkg::*;
#(
   parameter int VW         = 9,
   parameter int IW         = 10,
   parameter int LSB_MV     = 5,
   parameter int CLK_MHZ    = 100,
   parameter int RAMP_DIV   = 100,
   parameter int OV_OFS_MV  = 350,
   parameter int OV_FLR_MV  = 1350,
   parameter int OV_BOOT_MV = 2450,
   parameter int OV_REL_MV  = 2100,
   parameter int UV_OFS_MV  = 650
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [VW-1:0] vout_code,
   input  logic [VW-1:0] vid_code,
   input  logic [IW-1:0] isum_code,
   input  logic [IW-1:0] ilim_code,
   input  logic          dvid_active,
   input  logic          dvid_up,
   input  logic          pwm_pulse,
   output logic          vr_ready,
   output logic [1:0]    pwm_cmd,
   output logic [1:0]    fault_code,
   output logic [VW-1:0] dac_target
);

   localparam int OV_OFS_C  = mv_to_code(OV_OFS_MV, LSB_MV);
   localparam int OV_FLR_C  = mv_to_code(OV_FLR_MV, LSB_MV);
   localparam int OV_BOOT_C = mv_to_code(OV_BOOT_MV, LSB_MV);
   localparam int OV_REL_C  = mv_to_code(OV_REL_MV, LSB_MV);
   localparam int UV_OFS_C  = mv_to_code(UV_OFS_MV, LSB_MV);
   localparam int OV_FILT   = us_to_clk(5, CLK_MHZ);
   localparam int UV_FILT   = us_to_clk(30, CLK_MHZ);
   localparam int OC_LONG   = us_to_clk(400, CLK_MHZ);
   localparam int OC_SHORT  = us_to_clk(5, CLK_MHZ);
   localparam int OC_POST   = us_to_clk(800, CLK_MHZ);
   localparam int OV_DELAY  = us_to_clk(600, CLK_MHZ);
   localparam int CW        = $clog2(OC_LONG + 1);

   generate
      if (OV_BOOT_C >= (1 << VW)) begin : g_bad_vw
         $error("VW too narrow for the start-up over-voltage level");
      end
      if (OV_FILT < 2 || OC_SHORT < 2) begin : g_bad_clk
         $error("CLK_MHZ too low for the shortest filter");
      end
      if (RAMP_DIV < 1) begin : g_bad_div
         $error("RAMP_DIV must be at least 1");
      end
   endgenerate

   flt_e                               fault_q;
   logic                               vid_zero;
   logic                               ov_cond, uv_cond, oc_cond;
   logic                               oc_mask, oc_short, released;
   logic                               ov_take;
   logic [FILTER_COUNT-1:0]            f_cond, f_hit;
   logic [FILTER_COUNT-1:0][CW-1:0]    f_lim;
   logic [VW+1:0]                      uv_sum;

   assign vid_zero = (vid_code == '0);
   assign uv_sum   = {2'b00, vout_code} + (VW+2)'(UV_OFS_C);
   assign uv_cond  = ~vid_zero & (uv_sum < {2'b00, vid_code});
   assign oc_cond  = ~oc_mask & (isum_code > ilim_code);

   assign f_cond[IDX_OV] = ov_cond;
   assign f_cond[IDX_UV] = uv_cond;
   assign f_cond[IDX_OC] = oc_cond;
   assign f_lim[IDX_OV]  = CW'(OV_FILT);
   assign f_lim[IDX_UV]  = CW'(UV_FILT);
   assign f_lim[IDX_OC]  = oc_short ? CW'(OC_SHORT) : CW'(OC_LONG);

   for (genvar g = 0; g < FILTER_COUNT; g++) begin : g_filt
      vr_persist_filter #(.CW(CW)) u_filt (
         .clk   (clk),
         .rst_n (rst_n),
         .cond  (f_cond[g]),
         .limit (f_lim[g]),
         .hit   (f_hit[g])
      );
   end

   vr_ov_window #(
      .VW(VW), .OFS_C(OV_OFS_C), .FLOOR_C(OV_FLR_C),
      .BOOT_C(OV_BOOT_C), .BREL_C(OV_REL_C)
   ) u_ovw (
      .clk         (clk),
      .rst_n       (rst_n),
      .vid_code    (vid_code),
      .vout_code   (vout_code),
      .dvid_active (dvid_active),
      .pwm_pulse   (pwm_pulse),
      .take        (ov_take),
      .latched     (fault_q == FLT_OV),
      .ov_cond     (ov_cond),
      .released    (released)
   );

   vr_oc_window #(.POST(OC_POST)) u_ocw (
      .clk         (clk),
      .rst_n       (rst_n),
      .dvid_active (dvid_active),
      .dvid_up     (dvid_up),
      .vid_zero    (vid_zero),
      .oc_mask     (oc_mask),
      .oc_short    (oc_short)
   );

   vr_ov_ramp #(.VW(VW), .DELAY(OV_DELAY), .DIV(RAMP_DIV)) u_ramp (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (ov_take),
      .hold       (fault_q == FLT_OV),
      .vid_code   (vid_code),
      .dac_target (dac_target)
   );

   assign ov_take = (fault_q == FLT_NONE) & f_hit[IDX_OV];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_q <= FLT_NONE;
      end else if (fault_q == FLT_NONE) begin
         if (f_hit[IDX_OV])      fault_q <= FLT_OV;
         else if (f_hit[IDX_UV]) fault_q <= FLT_UV;
         else if (f_hit[IDX_OC]) fault_q <= FLT_OC;
      end
   end

   always_comb begin
      unique case (fault_q)
         FLT_NONE: pwm_cmd = DRV_RUN;
         FLT_OV:   pwm_cmd = released ? DRV_NOON : DRV_LOW;
         default:  pwm_cmd = DRV_TRI;
      endcase
   end

   assign vr_ready   = (fault_q == FLT_NONE);
   assign fault_code = fault_q;

   assert_code_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_q != FLT_NONE) |=> $stable(fault_q));

   assert_ov_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_q == FLT_NONE && f_hit[IDX_OV]) |=> (fault_q == FLT_OV));

   assert_zero_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
      vid_zero |-> (!f_hit[IDX_OV] && !f_hit[IDX_OC]));

endmodule

// File: tb/vr_fault_supervisor_bench.sv
module vr_fault_supervisor_bench;

   localparam int VW = 9;
   localparam int IW = 10;
   localparam int DIV = 100;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [VW-1:0] vout_code = '0, vid_code = '0;
   logic [IW-1:0] isum_code = '0, ilim_code = 10'd100;
   logic          dvid_active = 1'b0, dvid_up = 1'b0, pwm_pulse = 1'b0;
   logic          vr_ready;
   logic [1:0]    pwm_cmd, fault_code;
   logic [VW-1:0] dac_target;

   vr_fault_supervisor #(.VW(VW), .IW(IW), .RAMP_DIV(DIV)) u_vr_fault_supervisor (
      .clk(clk), .rst_n(rst_n), .vout_code(vout_code), .vid_code(vid_code),
      .isum_code(isum_code), .ilim_code(ilim_code), .dvid_active(dvid_active),
      .dvid_up(dvid_up), .pwm_pulse(pwm_pulse), .vr_ready(vr_ready),
      .pwm_cmd(pwm_cmd), .fault_code(fault_code), .dac_target(dac_target)
   );

   always #5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int    at;
      int    kind;
      int    val;
      string req;
   } exp_t;

   exp_t sb[$];
   int   n_vec = 0;
   int   n_bad = 0;
   bit   done = 1'b0;

   // kinds: 0 ready, 1 pwm_cmd, 2 fault_code, 3 dac_target
   task automatic expect_at(input int at, input int kind, input int val, input string req);
      exp_t e;
      e.at = at; e.kind = kind; e.val = val; e.req = req;
      sb.push_back(e);
   endtask

   // monitor: pops the items due on this edge count
   always @(negedge clk) begin
      for (int i = sb.size() - 1; i >= 0; i--) begin
         if (sb[i].at <= cyc) begin
            int got;
            case (sb[i].kind)
               0:       got = int'(vr_ready);
               1:       got = int'(pwm_cmd);
               2:       got = int'(fault_code);
               default: got = int'(dac_target);
            endcase
            n_vec++;
            if (sb[i].at != cyc || got != sb[i].val) begin
               n_bad++;
               $display("FAIL %s kind %0d at edge %0d (due %0d): actual %0d expected %0d",
                        sb[i].req, sb[i].kind, cyc, sb[i].at, got, sb[i].val);
            end
            sb.delete(i);
         end
      end
   end

   task automatic sync();
      @(posedge clk);
      #1;
   endtask

   task automatic wait_n(input int n);
      repeat (n) sync();
   endtask

   task automatic wait_until(input int at);
      while (cyc <= at) sync();
   endtask

   task automatic do_reset(input int vid);
      rst_n = 1'b0;
      vid_code = VW'(vid); vout_code = VW'(vid);
      isum_code = '0; ilim_code = 10'd100;
      dvid_active = 1'b0; dvid_up = 1'b0; pwm_pulse = 1'b0;
      wait_n(3);
      rst_n = 1'b1;
      wait_n(3);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      int b, te;
      // R1 reset state
      do_reset(200);
      b = cyc;
      expect_at(b, 0, 1, "R1"); expect_at(b, 1, 0, "R1");
      expect_at(b, 2, 0, "R1"); expect_at(b, 3, 200, "R1");
      wait_n(2);

      // R2 floor: VID 100 gives level 270, equal does not trip
      vid_code = 9'd100; vout_code = 9'd270; b = cyc;
      expect_at(b + 60, 0, 1, "R2 floor");
      wait_n(62);
      // R2 offset: VID 240 gives level 310
      vid_code = 9'd240; vout_code = 9'd310; b = cyc;
      expect_at(b + 60, 0, 1, "R2 offset");
      wait_n(62);
      // R4 trip timing
      vout_code = 9'd311; b = cyc; te = b + 50;
      expect_at(te - 1, 0, 1, "R4"); expect_at(te, 0, 0, "R4");
      expect_at(te + 1, 1, 1, "R4"); expect_at(te + 1, 2, 1, "R4");
      wait_n(55);
      // R6 VID input ignored after trip
      vid_code = 9'd100; b = cyc;
      expect_at(b, 3, 240, "R6 hold");
      // R5 release below captured VID
      vout_code = 9'd245; b = cyc;
      expect_at(b + 3, 1, 1, "R5 above vid");
      wait_n(5);
      vout_code = 9'd239; b = cyc;
      expect_at(b, 1, 1, "R5"); expect_at(b + 1, 1, 3, "R5 release");
      // R6 ramp timing
      expect_at(te + 6000 + DIV - 1, 3, 240, "R6 first step");
      expect_at(te + 6000 + DIV, 3, 239, "R6 first step");
      expect_at(te + 6000 + 240 * DIV - 1, 3, 1, "R6 end");
      expect_at(te + 6000 + 240 * DIV, 3, 0, "R6 end");
      expect_at(te + 6000 + 240 * DIV + 5, 3, 0, "R6 floor");
      wait_until(te + 6000 + 240 * DIV + 6);

      // R11 VID zero masks OV and OC
      do_reset(0);
      vout_code = 9'd400; isum_code = 10'd200; b = cyc;
      expect_at(b + 4100, 0, 1, "R11");
      wait_n(4102);
      // R3 start-up level 490
      isum_code = '0; vid_code = 9'd220; dvid_active = 1'b1; dvid_up = 1'b1;
      vout_code = 9'd480; b = cyc;
      expect_at(b + 100, 0, 1, "R3 below boot");
      wait_n(102);
      vout_code = 9'd495; b = cyc;
      expect_at(b + 49, 0, 1, "R3"); expect_at(b + 50, 0, 0, "R3 boot trip");
      wait_n(55);
      vout_code = 9'd425; b = cyc;
      expect_at(b + 3, 1, 1, "R5 boot hold");
      wait_n(5);
      vout_code = 9'd419; b = cyc;
      expect_at(b, 1, 1, "R5"); expect_at(b + 1, 1, 3, "R5 boot release");
      wait_n(3);

      // R3 window closes on first pulse after settling
      do_reset(0);
      vid_code = 9'd220; dvid_active = 1'b1; dvid_up = 1'b1;
      wait_n(20);
      dvid_active = 1'b0; vout_code = 9'd295; b = cyc;
      expect_at(b + 60, 0, 1, "R3 window open");
      wait_n(62);
      pwm_pulse = 1'b1;
      sync();
      pwm_pulse = 1'b0; b = cyc;
      expect_at(b + 49, 0, 1, "R3"); expect_at(b + 50, 0, 0, "R3 window closed");
      wait_n(55);

      // R7 under-voltage
      do_reset(200);
      vout_code = 9'd70; b = cyc;
      expect_at(b + 305, 0, 1, "R7 boundary");
      wait_n(307);
      vout_code = 9'd69; b = cyc;
      expect_at(b + 299, 0, 1, "R7"); expect_at(b + 300, 0, 0, "R7");
      expect_at(b + 301, 1, 2, "R7"); expect_at(b + 301, 2, 2, "R7");
      wait_n(305);
      vout_code = 9'd300; isum_code = 10'd200; b = cyc;
      expect_at(b + 100, 2, 2, "R12 held");
      wait_n(102);

      // R8 over-current long filter
      do_reset(200);
      isum_code = 10'd100; b = cyc;
      expect_at(b + 4100, 0, 1, "R8 equal");
      wait_n(4102);
      isum_code = 10'd101; b = cyc;
      expect_at(b + 3999, 0, 1, "R8"); expect_at(b + 4000, 0, 0, "R8");
      expect_at(b + 4001, 1, 2, "R8"); expect_at(b + 4001, 2, 3, "R8");
      wait_n(4005);
      vout_code = 9'd300; b = cyc;
      expect_at(b + 100, 2, 3, "R12 held"); expect_at(b + 100, 1, 2, "R12 held");
      wait_n(102);

      // R9 first DVID up uses the short filter
      do_reset(200);
      dvid_active = 1'b1; dvid_up = 1'b1; isum_code = 10'd101; b = cyc;
      expect_at(b + 49, 0, 1, "R9"); expect_at(b + 50, 0, 0, "R9");
      expect_at(b + 51, 2, 3, "R9");
      wait_n(55);

      // R12 OV and OC on the same edge
      do_reset(200);
      dvid_active = 1'b1; dvid_up = 1'b1; isum_code = 10'd101; vout_code = 9'd300; b = cyc;
      expect_at(b + 51, 2, 1, "R12 priority"); expect_at(b + 51, 1, 1, "R12 priority");
      wait_n(55);

      // R10 later DVID and its tail are masked
      do_reset(200);
      dvid_active = 1'b1; dvid_up = 1'b1;
      wait_n(10);
      dvid_active = 1'b0;
      wait_n(8010);
      dvid_active = 1'b1; isum_code = 10'd101; b = cyc;
      expect_at(b + 4100, 0, 1, "R10 during");
      wait_n(4102);
      dvid_active = 1'b0; b = cyc;
      expect_at(b + 6000, 0, 1, "R10 tail");
      expect_at(b + 12000, 0, 1, "R10"); expect_at(b + 12001, 0, 0, "R10");
      wait_n(12005);

      wait_n(2);
      if (sb.size() != 0) begin
         n_bad++;
         $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
      end
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog R1..: actual running expected finished");
         summary();
         $finish;
      end
   end

endmodule